// File: doc/BRIEF.md
# Receive Byte Queue with Interrupt Flags

This block sits behind an infrared pulse encoder. The encoder hands it one byte at a time with a push strobe and marks the end of each burst with a single-cycle pulse. The block keeps the bytes in a first-in first-out store and presents them to a processor through a small register map. The map is reached with plain read and write strobes, an 8-bit address and a 32-bit data word. Reading the data register takes the oldest byte out of the store.

Three events are tracked as sticky flags: a byte lost because the store was full, the end of a burst, and the store filling to a level that software programs. Each flag has its own enable bit. A single interrupt line is raised while any enabled flag is pending. Software clears flags by writing ones to the status word. The status word also reports how many bytes are held at that moment. The control, receive-config and sample-config registers only hold settings. Their fields are driven out to the neighbouring pulse decoder as configuration outputs.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, every configuration output is zero, the status word (0x30) reads 0, the interrupt line is low and the store is empty.
- R2: Writes store fields that appear on the configuration outputs one cycle later and read back in place, with all other bits reading zero. The fields are: at 0x00, bit 0 block enable, bit 1 receive enable and bits 5:4 mode; at 0x10, bit 2 input invert; at 0x34, bits 7:2 noise threshold and bits 15:8 idle threshold.
- R3: A push is accepted only while bits 0 and 1 of 0x00 are both set. A read of 0x20 returns the oldest held byte in bits 7:0 and removes it. The store holds 16 bytes.
- R4: A push while 16 bytes are held, with no removal in the same cycle, discards the byte, keeps the count at 16 and sets the overflow flag.
- R5: The status word at 0x30 holds the overflow flag in bit 0, the end-of-burst flag in bit 1 and the level flag in bit 4. Bits 13:8 hold the current byte count, and all other bits are zero.
- R6: The level flag sets when an accepted push leaves the count at or above the trigger field (bits 11:8 of 0x2C) plus one. The flag stays set as bytes are removed, and it sets again on a later push if the count still meets the level.
- R7: A write to 0x30 clears each flag whose bit in the written word is 1. If an event for a flag happens in the same cycle as its clear, the flag ends up set.
- R8: The interrupt line, updated in the cycle after a flag or enable changes, is high exactly when some flag is set together with its enable bit in 0x2C. The enable bits are bit 0 for overflow, bit 1 for end of burst and bit 4 for level.
- R9: A read of 0x20 while the store is empty returns 0 and leaves the count unchanged.
- R10: A push and a removal in the same cycle both take effect and the count is unchanged. With 16 bytes held, such a push is accepted and does not set the overflow flag.
- R11: While the block or the receive path is disabled, pushes and end-of-burst pulses change neither the count nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Encoder byte strobe |
| pushData | input | 8 | Encoder byte |
| pktEnd | input | 1 | End-of-burst pulse |
| busWrite | input | 1 | Register write strobe |
| busRead | input | 1 | Register read strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRead |
| irq | output | 1 | Interrupt request |
| cfgEnable | output | 1 | Block enable |
| cfgRxEnable | output | 1 | Receive enable |
| cfgMode | output | 2 | Decoder mode |
| cfgInvert | output | 1 | Input polarity invert |
| cfgNoise | output | 6 | Noise threshold in samples |
| cfgIdle | output | 8 | Idle threshold in samples |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a push and a read of the data register. The bench fills the store to 16 bytes and then pushes while it reads. It judges the outcome by the popped byte, the count and the overflow bit in the status word, which must show no loss. The second pair is an end-of-burst pulse and a write that clears that flag. The bench drives both in one cycle and expects the flag to survive and the interrupt to stay high.

// File: rtl/rbq_pkg.sv
package rbq_pkg;
  localparam logic [7:0] ADDR_CTRL  = 8'h00;
  localparam logic [7:0] ADDR_RXCFG = 8'h10;
  localparam logic [7:0] ADDR_DATA  = 8'h20;
  localparam logic [7:0] ADDR_IEN   = 8'h2C;
  localparam logic [7:0] ADDR_STAT  = 8'h30;
  localparam logic [7:0] ADDR_SAMP  = 8'h34;

  // flag positions shared by the enable and status words
  localparam int BIT_OVF   = 0;
  localparam int BIT_PKT   = 1;
  localparam int BIT_AVAIL = 4;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/rbq_fifo.sv
module rbq_fifo
  import rbq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headData = empty ? '0 : mem[rdPtr];

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |=> count == $past(count) + 1'b1);
  assert_both_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop) |=> count == $past(count));
endmodule

// File: rtl/rbq_ctrl.sv
module rbq_ctrl
  import rbq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TH_W  = CNT_W + 1,
  localparam int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              pktEnd,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [7:0]        busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [DATA_W-1:0] headData,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       strobe,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic              cfgEnable,
  output logic              cfgRxEnable,
  output logic [1:0]        cfgMode,
  output logic              cfgInvert,
  output logic [5:0]        cfgNoise,
  output logic [7:0]        cfgIdle
);
  logic             enOvf, enPkt, enAvail;
  logic [LVL_W-1:0] trigLvl;
  logic             flagOvf, flagPkt, flagAvail;

  logic             enabled, popHit, ovfEvent, pktEvent, availEvent;
  logic             wrCtrl, wrRxcfg, wrIen, wrStat, wrSamp;
  logic [TH_W-1:0]  nextCount, threshold;

  assign enabled  = cfgEnable && cfgRxEnable;
  assign popHit   = busRead && (busAddr == ADDR_DATA) && !empty;
  assign strobe.pop  = popHit;
  assign strobe.push = enabled && pushValid && (!full || popHit);

  assign ovfEvent   = enabled && pushValid && full && !popHit;
  assign pktEvent   = enabled && pktEnd;
  assign nextCount  = TH_W'(count) + TH_W'(strobe.push) - TH_W'(popHit);
  assign threshold  = TH_W'(trigLvl) + TH_W'(1);
  assign availEvent = strobe.push && (nextCount >= threshold);

  assign wrCtrl  = busWrite && (busAddr == ADDR_CTRL);
  assign wrRxcfg = busWrite && (busAddr == ADDR_RXCFG);
  assign wrIen   = busWrite && (busAddr == ADDR_IEN);
  assign wrStat  = busWrite && (busAddr == ADDR_STAT);
  assign wrSamp  = busWrite && (busAddr == ADDR_SAMP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable   <= 1'b0;
      cfgRxEnable <= 1'b0;
      cfgMode     <= '0;
      cfgInvert   <= 1'b0;
      cfgNoise    <= '0;
      cfgIdle     <= '0;
      enOvf       <= 1'b0;
      enPkt       <= 1'b0;
      enAvail     <= 1'b0;
      trigLvl     <= '0;
    end else begin
      if (wrCtrl) begin
        cfgEnable   <= busWdata[0];
        cfgRxEnable <= busWdata[1];
        cfgMode     <= busWdata[5:4];
      end
      if (wrRxcfg) cfgInvert <= busWdata[2];
      if (wrSamp) begin
        cfgNoise <= busWdata[7:2];
        cfgIdle  <= busWdata[15:8];
      end
      if (wrIen) begin
        enOvf   <= busWdata[BIT_OVF];
        enPkt   <= busWdata[BIT_PKT];
        enAvail <= busWdata[BIT_AVAIL];
        trigLvl <= busWdata[8 +: LVL_W];
      end
    end
  end

  // sticky flags: a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagOvf   <= 1'b0;
      flagPkt   <= 1'b0;
      flagAvail <= 1'b0;
    end else begin
      flagOvf   <= (flagOvf   && !(wrStat && busWdata[BIT_OVF]))   || ovfEvent;
      flagPkt   <= (flagPkt   && !(wrStat && busWdata[BIT_PKT]))   || pktEvent;
      flagAvail <= (flagAvail && !(wrStat && busWdata[BIT_AVAIL])) || availEvent;
    end
  end

  assign irq = (flagOvf && enOvf) || (flagPkt && enPkt) || (flagAvail && enAvail);

  always_comb begin
    busRdata = '0;
    if (busRead) begin
      case (busAddr)
        ADDR_CTRL: begin
          busRdata[0]   = cfgEnable;
          busRdata[1]   = cfgRxEnable;
          busRdata[5:4] = cfgMode;
        end
        ADDR_RXCFG: busRdata[2] = cfgInvert;
        ADDR_DATA:  busRdata[DATA_W-1:0] = headData;
        ADDR_IEN: begin
          busRdata[BIT_OVF]    = enOvf;
          busRdata[BIT_PKT]    = enPkt;
          busRdata[BIT_AVAIL]  = enAvail;
          busRdata[8 +: LVL_W] = trigLvl;
        end
        ADDR_STAT: begin
          busRdata[BIT_OVF]   = flagOvf;
          busRdata[BIT_PKT]   = flagPkt;
          busRdata[BIT_AVAIL] = flagAvail;
          busRdata[13:8]      = 6'(count);
        end
        ADDR_SAMP: begin
          busRdata[7:2]  = cfgNoise;
          busRdata[15:8] = cfgIdle;
        end
        default: busRdata = '0;
      endcase
    end
  end

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && pushValid && full && !popHit) |=> flagOvf);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !busWrite) |=> irq);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> ($stable(cfgMode) && $stable(cfgIdle) && $stable(cfgNoise)));
  assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !popHit) |=> count == $past(count));
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == ADDR_DATA && empty) |-> busRdata == '0);
  assert_clear_vs_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    pktEvent |=> flagPkt);
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rbq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pktEnd,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              cfgEnable,
  output logic              cfgRxEnable,
  output logic [1:0]        cfgMode,
  output logic              cfgInvert,
  output logic [5:0]        cfgNoise,
  output logic [7:0]        cfgIdle
);
  fifoStrobe_t       strobe;
  logic [DATA_W-1:0] headData;
  logic [CNT_W-1:0]  count;
  logic              full, empty;

  rbq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pktEnd(pktEnd),
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .headData(headData), .count(count),
    .full(full), .empty(empty), .strobe(strobe), .busRdata(busRdata),
    .irq(irq), .cfgEnable(cfgEnable), .cfgRxEnable(cfgRxEnable),
    .cfgMode(cfgMode), .cfgInvert(cfgInvert), .cfgNoise(cfgNoise),
    .cfgIdle(cfgIdle)
  );

  rbq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uFifo (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .headData(headData), .count(count), .full(full), .empty(empty)
  );
endmodule

// File: tb/tb_rx_byte_queue.sv
`timescale 1ns/1ps
module tb_rx_byte_queue;
  localparam logic [7:0] A_CTRL = 8'h00, A_RXCFG = 8'h10, A_DATA = 8'h20,
                         A_IEN = 8'h2C, A_STAT = 8'h30, A_SAMP = 8'h34;

  logic clk = 0, rstN = 0;
  logic pushValid = 0, pktEnd = 0, busWrite = 0, busRead = 0;
  logic [7:0]  pushData = 0, busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic irq, cfgEnable, cfgRxEnable, cfgInvert;
  logic [1:0] cfgMode;
  logic [5:0] cfgNoise;
  logic [7:0] cfgIdle;

  int checks = 0, fails = 0;
  int mCount = 0;
  bit modelEn = 0;
  logic [7:0] expQ[$];
  logic [31:0] rdSample, monData;
  event popEv;

  always #2.5 clk = ~clk;

  rx_byte_queue dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pktEnd(pktEnd), .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .cfgEnable(cfgEnable),
    .cfgRxEnable(cfgRxEnable), .cfgMode(cfgMode), .cfgInvert(cfgInvert),
    .cfgNoise(cfgNoise), .cfgIdle(cfgIdle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit p, input logic [7:0] pd, input bit pk, input bit w,
                      input bit r, input logic [7:0] a, input logic [31:0] wd);
    @(negedge clk);
    pushValid = p; pushData = pd; pktEnd = pk;
    busWrite = w; busRead = r; busAddr = a; busWdata = wd;
    #1 rdSample = busRdata;
    if (r && a == A_DATA) begin monData = rdSample; ->popEv; end
    @(posedge clk);
    #1 pushValid = 0; pktEnd = 0; busWrite = 0; busRead = 0;
  endtask

  // scoreboard driver side: queue the byte the model expects to be kept
  task automatic pushB(input logic [7:0] d);
    step(1, d, 0, 0, 0, 8'h00, 0);
    if (modelEn && mCount < 16) begin expQ.push_back(d); mCount++; end
  endtask

  task automatic popB();
    step(0, 0, 0, 0, 1, A_DATA, 0);
    if (mCount > 0) mCount--;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(0, 0, 0, 1, 0, a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    step(0, 0, 0, 0, 1, a, 0);
    d = rdSample;
  endtask

  function automatic logic [31:0] st(input bit o, input bit p, input bit av, input int c);
    return (32'(c) << 8) | (32'(av) << 4) | (32'(p) << 1) | 32'(o);
  endfunction

  // scoreboard monitor side
  initial begin
    forever begin
      @(popEv);
      if (expQ.size() == 0) chk("R9 empty read", monData, 0);
      else chk("R3 pop order", monData, {24'b0, expQ.pop_front()});
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cfg", {cfgEnable, cfgRxEnable, cfgMode, cfgInvert, cfgNoise, cfgIdle}, 0);
    // R11 disabled block ignores push and burst end
    pushB(8'hAA);
    step(0, 0, 1, 0, 0, 8'h00, 0);
    rd(A_STAT, v); chk("R11 disabled", v, 0);
    // R2 configuration fields
    wr(A_SAMP, 32'h0000_1405);
    chk("R2 noise", {26'b0, cfgNoise}, 1);
    chk("R2 idle", {24'b0, cfgIdle}, 8'h14);
    rd(A_SAMP, v); chk("R2 samp readback", v, 32'h1404);
    wr(A_RXCFG, 32'hFF);
    rd(A_RXCFG, v); chk("R2 rxcfg readback", v, 32'h4);
    chk("R2 invert", {31'b0, cfgInvert}, 1);
    wr(A_CTRL, 32'hFF33);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h33);
    chk("R2 mode", {30'b0, cfgMode}, 3);
    modelEn = 1;
    // R6 R8 level flag with trigger field 7
    wr(A_IEN, 32'h0713);
    rd(A_IEN, v); chk("R8 ien readback", v, 32'h0713);
    for (int i = 0; i < 7; i++) pushB(8'h10 + 8'(i));
    rd(A_STAT, v); chk("R6 below level", v, st(0, 0, 0, 7));
    chk("R8 irq low", {31'b0, irq}, 0);
    pushB(8'h17);
    rd(A_STAT, v); chk("R5 R6 at level", v, st(0, 0, 1, 8));
    chk("R8 irq high", {31'b0, irq}, 1);
    for (int i = 0; i < 8; i++) popB();
    rd(A_STAT, v); chk("R6 sticky", v, st(0, 0, 1, 0));
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R7 clear", v, 0);
    chk("R8 irq after clear", {31'b0, irq}, 0);
    // R9 empty read
    popB();
    rd(A_STAT, v); chk("R9 count kept", v, 0);
    // R4 overflow
    for (int i = 0; i < 16; i++) pushB(8'h40 + 8'(i));
    rd(A_STAT, v); chk("R3 full", v, st(0, 0, 1, 16));
    pushB(8'h99);
    rd(A_STAT, v); chk("R4 overflow", v, st(1, 0, 1, 16));
    chk("R8 irq ovf", {31'b0, irq}, 1);
    for (int i = 0; i < 16; i++) popB();
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); chk("R7 clear all", v, 0);
    // R10 push and pop in one cycle while full
    for (int i = 0; i < 16; i++) pushB(8'h60 + 8'(i));
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); chk("R7 clear keeps count", v, st(0, 0, 0, 16));
    step(1, 8'h77, 0, 0, 1, A_DATA, 0);
    expQ.push_back(8'h77);
    rd(A_STAT, v); chk("R10 no loss", v, st(0, 0, 1, 16));
    for (int i = 0; i < 16; i++) popB();
    rd(A_STAT, v); chk("R10 drained", v, st(0, 0, 1, 0));
    // R7 event wins over clear in the same cycle
    wr(A_STAT, 32'hFF);
    step(0, 0, 1, 1, 0, A_STAT, 32'h02);
    rd(A_STAT, v); chk("R7 event beats clear", v, st(0, 1, 0, 0));
    chk("R8 irq pkt", {31'b0, irq}, 1);
    wr(A_IEN, 32'h0711);
    chk("R8 irq masked", {31'b0, irq}, 0);
    // R6 flag sets again on a later push
    wr(A_IEN, 32'h0313);
    for (int i = 0; i < 4; i++) pushB(8'h80 + 8'(i));
    rd(A_STAT, v); chk("R6 level 4", v, st(0, 1, 1, 4));
    wr(A_STAT, 32'h10);
    pushB(8'h84);
    rd(A_STAT, v); chk("R6 re-set", v, st(0, 1, 1, 5));
    // R11 receive path off
    wr(A_CTRL, 32'h31);
    modelEn = 0;
    pushB(8'hEE);
    step(0, 0, 1, 1, 0, A_STAT, 32'h02);
    rd(A_STAT, v); chk("R11 rx off", v, st(0, 0, 1, 5));
    for (int i = 0; i < 5; i++) popB();
    rd(A_STAT, v); chk("R3 final drain", v, st(0, 0, 1, 0));
    chk("R3 queue empty", 32'(expQ.size()), 0);
    finishRun();
  end
endmodule